// File: doc/BRIEF.md
# Register Dump Byte Streamer

This block sends the contents of a small register file to an external debug host, one byte per host transfer. After a dump command, a loader walks the registers from index 0 upward and splits each register into bytes, low byte first. It waits a programmable number of cycles before each byte, which stands in for the firmware service routine. It writes each byte into an 8-bit holding register and sets a transfer-complete flag.

The host sees a 2-bit status and the holding register. When the flag is set, the byte is tagged valid. The host then pulses a one-cycle transfer strobe to take it, and this strobe clears the flag so the loader can prepare the next byte. While the flag is clear the status reads busy. When the final byte has been taken, the status reads idle and a new dump may be started.

The register file is modelled as a flat input vector. Each register has a slot of `MAX_BYTES` bytes, and a per-entry byte count parameter gives its width. The serial scan path is reduced to the strobe and a parallel byte output.

Top module: `regdump_streamer`

## Requirements
- R1: After reset, status is idle (01b), the transfer-complete flag is 0 and the data output is 0.
- R2: A dump command accepted in idle makes the status busy (10b) from the next cycle until the first byte is loaded.
- R3: A loaded byte is shown with status valid (11b) and the flag at 1. Status and data stay unchanged until the host strobes.
- R4: Bytes are sent in ascending register index and low byte first within a register. A register with a byte count of N occupies N transfers; a byte count of 2 means two transfers for a 16-bit register. Byte b of register r is taken from data bits [(r*MAX_BYTES+b)*8 +: 8].
- R5: A strobe while status is valid clears the flag in the next cycle, and status returns to busy if bytes remain.
- R6: After a dump command or a taken byte, status reads busy for exactly LOAD_LAT+1 cycles before the next byte is valid.
- R7: A strobe while status is busy is ignored. No byte is skipped and the timing of the next load is unchanged.
- R8: The cycle after the host takes the final byte, status reads idle (01b).
- R9: A dump command while a dump is in progress is ignored.
- R10: A strobe while idle has no effect and status stays idle.
- R11: The data output reads 0 whenever status is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dump_start | input | 1 | One-cycle dump command |
| host_xfer | input | 1 | One-cycle host transfer strobe |
| reg_data | input | NUM_REGS*MAX_BYTES*8 | Register file contents, one slot per register |
| host_byte | output | 8 | Holding register as seen by the host |
| host_status | output | 2 | 01 idle, 10 busy, 11 valid |
| txc_flag | output | 1 | Transfer-complete handshake flag |

## Verification
The bench builds the block with four registers of 1, 2, 1 and 3 bytes in 3-byte slots and a load latency of 1. This covers a register split into several bytes, a register that fills its whole slot, and single-byte registers on both sides of wider ones. It also keeps the busy gap short enough to place strobes and dump commands inside it. Three dumps are run: one with a prompt host, one with strobes and commands injected during busy and valid phases, and one after the register contents change.

// File: rtl/regdump_pkg.sv
package regdump_pkg;
  typedef enum logic [1:0] {
    ST_NONE  = 2'b00,
    ST_IDLE  = 2'b01,
    ST_BUSY  = 2'b10,
    ST_VALID = 2'b11
  } dump_status_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/regdump_cursor.sv
module regdump_cursor #(
  parameter int unsigned NUM_REGS   = 5,
  parameter int unsigned MAX_BYTES  = 4,
  parameter logic [NUM_REGS*4-1:0] REG_NBYTES = '0,
  localparam int unsigned RIDX_W = regdump_pkg::idx_width(NUM_REGS),
  localparam int unsigned BIDX_W = regdump_pkg::idx_width(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [RIDX_W-1:0] reg_idx,
  output logic [BIDX_W-1:0] byte_idx,
  output logic              at_last
);
  logic [RIDX_W-1:0] reg_q, reg_d;
  logic [BIDX_W-1:0] byte_q, byte_d;
  logic [3:0]        nb_cur;
  logic              last_in_reg;
  logic              last_reg;

  always_comb begin
    nb_cur      = REG_NBYTES[int'(reg_q)*4 +: 4];
    last_in_reg = (int'(byte_q) + 1) >= int'(nb_cur);
    last_reg    = int'(reg_q) == (NUM_REGS - 1);
    at_last     = last_in_reg && last_reg;
  end

  always_comb begin
    reg_d  = reg_q;
    byte_d = byte_q;
    if (clear) begin
      reg_d  = '0;
      byte_d = '0;
    end else if (step) begin
      if (last_in_reg) begin
        byte_d = '0;
        reg_d  = last_reg ? '0 : reg_q + RIDX_W'(1);
      end else begin
        byte_d = byte_q + BIDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      byte_q <= '0;
    end else if (clear || step) begin
      reg_q  <= reg_d;
      byte_q <= byte_d;
    end
  end

  assign reg_idx  = reg_q;
  assign byte_idx = byte_q;

  // R4: the pointer stays within the implemented registers and their widths
  assert_cursor_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_q) < NUM_REGS) && (int'(byte_q) < int'(nb_cur)));

  // R4: a step from the end of one register lands on byte 0 of the next
  assert_next_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && last_in_reg && !last_reg) |=> (byte_q == '0));
endmodule

// File: rtl/regdump_bytesel.sv
module regdump_bytesel #(
  parameter int unsigned NUM_REGS  = 5,
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned SLOTS  = NUM_REGS * MAX_BYTES,
  localparam int unsigned RIDX_W = regdump_pkg::idx_width(NUM_REGS),
  localparam int unsigned BIDX_W = regdump_pkg::idx_width(MAX_BYTES)
) (
  input  logic [SLOTS*8-1:0] reg_data,
  input  logic [RIDX_W-1:0]  reg_idx,
  input  logic [BIDX_W-1:0]  byte_idx,
  output logic [7:0]         byte_out
);
  logic [7:0] slot_bytes [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_bytes[g] = reg_data[g*8 +: 8];
  end

  always_comb begin
    int sel;
    sel = int'(reg_idx) * MAX_BYTES + int'(byte_idx);
    byte_out = (sel < SLOTS) ? slot_bytes[sel] : 8'h00;
  end
endmodule

// File: rtl/regdump_loader.sv
module regdump_loader #(
  parameter int unsigned LOAD_LAT = 2,
  localparam int unsigned WAIT_W = regdump_pkg::idx_width(LOAD_LAT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       active,
  input  logic       take,
  input  logic [7:0] byte_in,
  input  logic       at_last,
  output logic       load,
  output logic       txc,
  output logic [7:0] hold,
  output logic       final_byte
);
  logic              txc_q, txc_d;
  logic [7:0]        hold_q, hold_d;
  logic              final_q, final_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              hold_en;

  assign load = active && !txc_q && (wait_q == '0);

  always_comb begin
    txc_d   = txc_q;
    final_d = final_q;
    wait_d  = wait_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (arm) begin
      txc_d   = 1'b0;
      final_d = 1'b0;
      wait_d  = WAIT_W'(LOAD_LAT);
    end else if (load) begin
      hold_en = 1'b1;
      hold_d  = byte_in;
      txc_d   = 1'b1;
      final_d = at_last;
    end else if (take) begin
      txc_d  = 1'b0;
      wait_d = WAIT_W'(LOAD_LAT);
    end else if (active && !txc_q) begin
      wait_d = wait_q - WAIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_q   <= 1'b0;
      final_q <= 1'b0;
      wait_q  <= '0;
    end else begin
      txc_q   <= txc_d;
      final_q <= final_d;
      wait_q  <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign txc        = txc_q;
  assign hold       = hold_q;
  assign final_byte = final_q;

  // R3: the flag stays set until the host takes the byte
  assert_txc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_q && !take && !arm) |=> txc_q);

  // R6: a byte is only written when the flag is clear and the wait has run out
  assert_load_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_q) |-> ($past(wait_q) == '0));
endmodule

// File: rtl/regdump_streamer.sv
module regdump_streamer #(
  parameter int unsigned NUM_REGS  = 5,
  parameter int unsigned MAX_BYTES = 4,
  parameter logic [NUM_REGS*4-1:0] REG_NBYTES = {4'd2, 4'd1, 4'd4, 4'd1, 4'd2},
  parameter int unsigned LOAD_LAT  = 2,
  localparam int unsigned DATA_W = NUM_REGS * MAX_BYTES * 8,
  localparam int unsigned RIDX_W = regdump_pkg::idx_width(NUM_REGS),
  localparam int unsigned BIDX_W = regdump_pkg::idx_width(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dump_start,
  input  logic              host_xfer,
  input  logic [DATA_W-1:0] reg_data,
  output logic [7:0]        host_byte,
  output logic [1:0]        host_status,
  output logic              txc_flag
);
  import regdump_pkg::*;

  logic              active_q, active_d;
  logic              arm;
  logic              take;
  logic              load;
  logic              txc;
  logic              final_byte;
  logic              at_last;
  logic [7:0]        hold;
  logic [7:0]        sel_byte;
  logic [RIDX_W-1:0] reg_idx;
  logic [BIDX_W-1:0] byte_idx;
  dump_status_e      status;

  assign arm  = dump_start && !active_q;
  assign take = active_q && txc && host_xfer;

  always_comb begin
    active_d = active_q;
    if (arm) begin
      active_d = 1'b1;
    end else if (take && final_byte) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  regdump_cursor #(
    .NUM_REGS  (NUM_REGS),
    .MAX_BYTES (MAX_BYTES),
    .REG_NBYTES(REG_NBYTES)
  ) i_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (arm),
    .step    (load),
    .reg_idx (reg_idx),
    .byte_idx(byte_idx),
    .at_last (at_last)
  );

  regdump_bytesel #(
    .NUM_REGS (NUM_REGS),
    .MAX_BYTES(MAX_BYTES)
  ) i_bytesel (
    .reg_data(reg_data),
    .reg_idx (reg_idx),
    .byte_idx(byte_idx),
    .byte_out(sel_byte)
  );

  regdump_loader #(
    .LOAD_LAT(LOAD_LAT)
  ) i_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .active    (active_q),
    .take      (take),
    .byte_in   (sel_byte),
    .at_last   (at_last),
    .load      (load),
    .txc       (txc),
    .hold      (hold),
    .final_byte(final_byte)
  );

  always_comb begin
    if (!active_q) begin
      status = ST_IDLE;
    end else if (txc) begin
      status = ST_VALID;
    end else begin
      status = ST_BUSY;
    end
  end

  assign host_status = status;
  assign host_byte   = (status == ST_VALID) ? hold : 8'h00;
  assign txc_flag    = txc;

  // R2: an accepted command shows busy on the following cycle
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_start && host_status == ST_IDLE) |=> (host_status == ST_BUSY));

  // R3: a valid byte holds still while the host has not strobed
  assert_valid_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status == ST_VALID && !host_xfer) |=> (host_status == ST_VALID && $stable(host_byte)));

  // R5: a strobe on a valid byte clears the flag
  assert_xfer_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status == ST_VALID && host_xfer) |=> !txc_flag);

  // R10: without a command, idle persists
  assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status == ST_IDLE && !dump_start) |=> (host_status == ST_IDLE));

  // R11: no stale data outside the valid phase
  assert_quiet_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status != ST_VALID) |-> (host_byte == 8'h00));
endmodule

// File: tb/test_regdump_streamer.sv
module test_regdump_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int MAXB = 3;
  localparam int LAT  = 1;
  localparam int NB [NREG] = '{1, 2, 1, 3};

  logic clk = 1'b0;
  logic rst_n;
  logic dump_start;
  logic host_xfer;
  logic [NREG*MAXB*8-1:0] reg_data;
  logic [7:0] host_byte;
  logic [1:0] host_status;
  logic txc_flag;

  logic [7:0] mem [NREG][MAXB];

  int total_checks = 0;
  int bad_checks = 0;

  // reference model state
  bit m_act, m_txc, m_final;
  int m_wait;
  logic [7:0] m_hold;
  logic [7:0] m_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < MAXB; b++)
        reg_data[(r*MAXB+b)*8 +: 8] = mem[r][b];
  end

  regdump_streamer #(
    .NUM_REGS  (NREG),
    .MAX_BYTES (MAXB),
    .REG_NBYTES({4'd3, 4'd1, 4'd2, 4'd1}),
    .LOAD_LAT  (LAT)
  ) i_regdump_streamer (
    .clk        (clk),
    .rst_n      (rst_n),
    .dump_start (dump_start),
    .host_xfer  (host_xfer),
    .reg_data   (reg_data),
    .host_byte  (host_byte),
    .host_status(host_status),
    .txc_flag   (txc_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void expected_list(ref logic [7:0] q [$]);
    q = {};
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < NB[r]; b++)
        q.push_back(mem[r][b]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_txc = 0; m_final = 0; m_wait = 0; m_hold = 8'h00; m_q = {};
    end else if (dump_start && !m_act) begin
      m_act = 1; m_txc = 0; m_final = 0; m_wait = LAT;
      expected_list(m_q);
    end else if (m_act) begin
      if (m_txc) begin
        if (host_xfer) begin
          m_txc = 0; m_wait = LAT;
          if (m_final) m_act = 0;
        end
      end else if (m_wait == 0) begin
        m_hold = m_q.pop_front();
        m_txc = 1;
        m_final = (m_q.size() == 0);
      end else begin
        m_wait--;
      end
    end
  end

  task automatic compare();
    logic [1:0] es;
    logic [7:0] eb;
    es = !m_act ? 2'b01 : (m_txc ? 2'b11 : 2'b10);
    eb = (es == 2'b11) ? m_hold : 8'h00;
    chk(host_status == es, (es == 2'b01) ? "R8 status" : (es == 2'b10) ? "R2 status" : "R3 status",
        int'(host_status), int'(es));
    chk(host_byte == eb, (es == 2'b11) ? "R4 data" : "R11 data", int'(host_byte), int'(eb));
    chk(txc_flag == m_txc, "R5 flag", int'(txc_flag), int'(m_txc));
  endtask

  task automatic cyc(input bit s, input bit x);
    dump_start = s;
    host_xfer = x;
    @(negedge clk);
    compare();
  endtask

  task automatic run_dump(input bit noisy);
    logic [7:0] got [$];
    logic [7:0] exp [$];
    int cnt;
    int total;
    expected_list(exp);
    total = exp.size();
    got = {};
    cyc(1, 0);
    forever begin
      cnt = 0;
      while (host_status == 2'b10 && cnt < 100) begin
        cnt++;
        // R7, R9: strobes and commands inside busy must be ignored
        cyc(noisy, noisy);
      end
      chk(cnt == LAT + 1, "R6 busy gap", cnt, LAT + 1);
      chk(host_status == 2'b11, "R3 valid", int'(host_status), 3);
      got.push_back(host_byte);
      if (noisy) begin
        logic [7:0] seen;
        seen = host_byte;
        cyc(1, 0);
        cyc(0, 0);
        chk(host_status == 2'b11 && host_byte == seen, "R9 start ignored", int'(host_byte), int'(seen));
      end
      cyc(0, 1);
      if (got.size() >= total || got.size() > 20) begin
        chk(host_status == 2'b01, "R8 idle after last", int'(host_status), 1);
        break;
      end
      chk(host_status == 2'b10, "R5 busy after take", int'(host_status), 2);
    end
    chk(got.size() == total, "R4 byte count", got.size(), total);
    for (int i = 0; i < total && i < got.size(); i++)
      chk(got[i] == exp[i], "R4 order", int'(got[i]), int'(exp[i]));
    cyc(0, 0);
  endtask

  task automatic main_flow();
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < MAXB; b++)
        mem[r][b] = 8'(16 * (r + 1) + b + 1);
    dump_start = 0;
    host_xfer = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(host_status == 2'b01, "R1 reset status", int'(host_status), 1);
    chk(txc_flag == 1'b0, "R1 reset flag", int'(txc_flag), 0);
    chk(host_byte == 8'h00, "R1 reset data", int'(host_byte), 0);
    rst_n = 1;
    @(negedge clk);
    compare();
    for (int i = 0; i < 3; i++) cyc(0, 1);
    chk(host_status == 2'b01, "R10 strobe in idle", int'(host_status), 1);
    run_dump(0);
    run_dump(1);
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < MAXB; b++)
        mem[r][b] = 8'(8'hA0 ^ (r * 7 + b * 3));
    run_dump(0);
    for (int i = 0; i < 2; i++) cyc(0, 1);
    chk(host_status == 2'b01, "R10 idle after dumps", int'(host_status), 1);
  endtask

  initial begin
    fork
      main_flow();
      begin
        repeat (20000) @(posedge clk);
        total_checks++;
        bad_checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule